// File: doc/BRIEF.md
# Multi-cycle accumulator processor core

This block is a small processor core with a single working register (the accumulator) and a single-port, word-addressed memory. Each instruction is carried out as a chain of register transfers, one per clock. The transfers pass through an address register that drives the memory address and a buffer register that holds the word read from or written to memory. A program counter points at the next instruction, and an instruction register holds the one being run.

Every instruction goes through the same phases. First a fetch phase reads the instruction word. Next comes an optional pointer phase, taken only when the instruction asks for indirect addressing: it reads a word from memory and uses that word's low bits as the operand address. Last comes the operation's own execute phase, after which the core fetches again. Memory reads return their data one cycle after the read strobe. A halt instruction stops the core until the next reset.

A system places a program at address 0, releases reset and waits for the halted output. Results are left in memory by store instructions.

Top module: `acc_core`

## Requirements
- R1: An instruction word holds the opcode in bits 3:0 and a 12-bit address in bits 15:4. Opcode bit 3 selects indirect addressing. Bits 2:0 select the operation: 0 halt, 1 load, 2 store, 3 add, 4 subtract, 5 jump, 6 jump-if-accumulator-zero, 7 no-op.
- R2: A fetch takes 5 cycles: the program counter is copied to the address output, a single read strobe cycle follows, the word is captured, the counter increments, and the word moves to the instruction register.
- R3: For an indirect instruction only, 4 extra cycles read the word at the address field, and that word's low 12 bits become the operand address. Direct instructions skip this phase.
- R4: Load, add and subtract each take 4 execute cycles. The accumulator becomes the memory word, the sum, or the difference accumulator minus word, modulo 2^16, with no flags.
- R5: A store takes 3 execute cycles. It ends with exactly one write strobe cycle, with the operand address on the address output and the accumulator on the write data output.
- R6: Jump, jump-if-zero and no-op take 1 execute cycle. Jump loads the address into the program counter. Jump-if-zero does so only when the accumulator is 0 and otherwise falls through.
- R7: A halt takes 1 execute cycle. After it, the halted output stays high and no memory strobe is issued until reset.
- R8: While reset is low, the strobes and halted are low, and the program counter, accumulator and all other registers are zero. The first fetch after reset reads address 0.
- R9: The program counter wraps from 4095 to 0.
- R10: The read and write strobes are never high together. Read data is taken in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Memory word address (address register) |
| mem_rd | output | 1 | Read strobe; data expected on mem_rdata the next cycle |
| mem_wr | output | 1 | Write strobe, one cycle per store |
| mem_wdata | output | 16 | Write data (buffer register) |
| mem_rdata | input | 16 | Read data from memory |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Random straight-line programs mix load, store, add, subtract, forward conditional jumps and no-ops, with direct and pointer operands; their pointer words carry random upper bits. Comparing the final memory and the cycle count with a bench model separates faults in operand selection from faults in phase length. Directed programs cover cases the random ones cannot reach:
- a pointer load, which exposes the extra read and its address;
- sums and differences that wrap;
- a taken jump that must skip a store;
- a conditional jump checked both taken and not taken;
- a jump to the top address, which forces the program counter to wrap;
- a halted core that must stay silent on the memory port.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [3:0] {
    PH_F_MAR, PH_F_RD, PH_F_CAP, PH_F_INC, PH_F_IR,
    PH_I_MAR, PH_I_RD, PH_I_CAP, PH_I_FIX,
    PH_X_DISP, PH_X_RD, PH_X_CAP, PH_X_ALU, PH_X_MBR, PH_X_WR,
    PH_HALT
  } phase_e;

  typedef enum logic [2:0] {
    OP_HALT  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_ADD   = 3'd3,
    OP_SUB   = 3'd4,
    OP_JUMP  = 3'd5,
    OP_JZ    = 3'd6,
    OP_NOP   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    R0_PASS = 2'd0,
    R0_ADD  = 2'd1,
    R0_SUB  = 2'd2
  } r0_sel_e;

  // one register transfer per clock; at most one source per destination
  typedef struct packed {
    logic    mar_pc;
    logic    mar_ir;
    logic    mbr_mem;
    logic    mbr_r0;
    logic    pc_inc;
    logic    pc_load;
    logic    ir_load;
    logic    ir_fix;
    logic    r0_load;
    r0_sel_e r0_sel;
  } uop_t;

endpackage

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
#(
  parameter int OPC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-2:0] ir_op,
  input  logic             mbr_ind,
  input  logic             r0_zero,
  output phase_e           phase,
  output uop_t             uop,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             halted
);

  phase_e ph_q;
  phase_e ph_d;
  op_e    op;

  assign op = op_e'(ir_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_F_MAR;
    else        ph_q <= ph_d;
  end

  always_comb begin
    ph_d   = ph_q;
    uop    = '0;
    mem_rd = 1'b0;
    mem_wr = 1'b0;
    case (ph_q)
      // fetch
      PH_F_MAR: begin uop.mar_pc  = 1'b1; ph_d = PH_F_RD;  end
      PH_F_RD:  begin mem_rd      = 1'b1; ph_d = PH_F_CAP; end
      PH_F_CAP: begin uop.mbr_mem = 1'b1; ph_d = PH_F_INC; end
      PH_F_INC: begin uop.pc_inc  = 1'b1; ph_d = PH_F_IR;  end
      PH_F_IR: begin
        uop.ir_load = 1'b1;
        ph_d = mbr_ind ? PH_I_MAR : PH_X_DISP;
      end
      // pointer resolution
      PH_I_MAR: begin uop.mar_ir  = 1'b1; ph_d = PH_I_RD;   end
      PH_I_RD:  begin mem_rd      = 1'b1; ph_d = PH_I_CAP;  end
      PH_I_CAP: begin uop.mbr_mem = 1'b1; ph_d = PH_I_FIX;  end
      PH_I_FIX: begin uop.ir_fix  = 1'b1; ph_d = PH_X_DISP; end
      // execute
      PH_X_DISP: begin
        case (op)
          OP_HALT: ph_d = PH_HALT;
          OP_LOAD, OP_ADD, OP_SUB: begin
            uop.mar_ir = 1'b1;
            ph_d = PH_X_RD;
          end
          OP_STORE: begin
            uop.mar_ir = 1'b1;
            ph_d = PH_X_MBR;
          end
          OP_JUMP: begin
            uop.pc_load = 1'b1;
            ph_d = PH_F_MAR;
          end
          OP_JZ: begin
            uop.pc_load = r0_zero;
            ph_d = PH_F_MAR;
          end
          default: ph_d = PH_F_MAR;
        endcase
      end
      PH_X_RD:  begin mem_rd      = 1'b1; ph_d = PH_X_CAP; end
      PH_X_CAP: begin uop.mbr_mem = 1'b1; ph_d = PH_X_ALU; end
      PH_X_ALU: begin
        uop.r0_load = 1'b1;
        case (op)
          OP_ADD:  uop.r0_sel = R0_ADD;
          OP_SUB:  uop.r0_sel = R0_SUB;
          default: uop.r0_sel = R0_PASS;
        endcase
        ph_d = PH_F_MAR;
      end
      PH_X_MBR: begin uop.mbr_r0 = 1'b1; ph_d = PH_X_WR;  end
      PH_X_WR:  begin mem_wr     = 1'b1; ph_d = PH_F_MAR; end
      PH_HALT:  ph_d = PH_HALT;
      default:  ph_d = PH_F_MAR;
    endcase
  end

  assign phase  = ph_q;
  assign halted = (ph_q == PH_HALT);

endmodule

// File: rtl/acc_regs.sv
module acc_regs
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OPC_W  = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  uop_t              uop,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [DATA_W-1:0] r0,
  output logic [ADDR_W-1:0] ir_addr,
  output logic [OPC_W-2:0]  ir_op,
  output logic              ir_ind,
  output logic              mbr_ind,
  output logic              r0_zero
);

  logic [DATA_W-1:0] ir;

  function automatic logic [ADDR_W-1:0] pc_step(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] r0_next(input r0_sel_e s,
                                                input logic [DATA_W-1:0] acc,
                                                input logic [DATA_W-1:0] opnd);
    case (s)
      R0_ADD:  return acc + opnd;
      R0_SUB:  return acc - opnd;
      default: return opnd;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      r0  <= '0;
    end else begin
      if (uop.mar_pc)       mar <= pc;
      else if (uop.mar_ir)  mar <= ir[DATA_W-1:OPC_W];

      if (uop.mbr_mem)      mbr <= mem_rdata;
      else if (uop.mbr_r0)  mbr <= r0;

      if (uop.pc_load)      pc <= ir[DATA_W-1:OPC_W];
      else if (uop.pc_inc)  pc <= pc_step(pc);

      if (uop.ir_load)      ir <= mbr;
      else if (uop.ir_fix)  ir[DATA_W-1:OPC_W] <= mbr[ADDR_W-1:0];

      if (uop.r0_load)      r0 <= r0_next(uop.r0_sel, r0, mbr);
    end
  end

  assign ir_addr = ir[DATA_W-1:OPC_W];
  assign ir_op   = ir[OPC_W-2:0];
  assign ir_ind  = ir[OPC_W-1];
  assign mbr_ind = mbr[OPC_W-1];
  assign r0_zero = (r0 == '0);

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter  int DATA_W = 16,
  parameter  int OPC_W  = 4,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);

  uop_t              uop;
  phase_e            phase;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mbr;
  logic [DATA_W-1:0] r0;
  logic [ADDR_W-1:0] ir_addr;
  logic [OPC_W-2:0]  ir_op;
  logic              ir_ind;
  logic              mbr_ind;
  logic              r0_zero;

  // named events for the checker
  logic ev_fetch_rd;
  logic ev_pc_inc;
  logic ev_ind_fix;
  logic ev_add;
  logic ev_sub;

  acc_seq #(.OPC_W(OPC_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ir_op   (ir_op),
    .mbr_ind (mbr_ind),
    .r0_zero (r0_zero),
    .phase   (phase),
    .uop     (uop),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .halted  (halted)
  );

  acc_regs #(.DATA_W(DATA_W), .OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .uop       (uop),
    .mem_rdata (mem_rdata),
    .pc        (pc),
    .mar       (mar),
    .mbr       (mbr),
    .r0        (r0),
    .ir_addr   (ir_addr),
    .ir_op     (ir_op),
    .ir_ind    (ir_ind),
    .mbr_ind   (mbr_ind),
    .r0_zero   (r0_zero)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mbr;

  assign ev_fetch_rd = (phase == PH_F_RD);
  assign ev_pc_inc   = uop.pc_inc;
  assign ev_ind_fix  = uop.ir_fix;
  assign ev_add      = uop.r0_load && (uop.r0_sel == R0_ADD);
  assign ev_sub      = uop.r0_load && (uop.r0_sel == R0_SUB);

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              halted,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] r0,
  input logic [DATA_W-1:0] mbr,
  input logic [ADDR_W-1:0] ir_addr,
  input logic              ir_ind,
  input logic              ev_fetch_rd,
  input logic              ev_pc_inc,
  input logic              ev_ind_fix,
  input logic              ev_add,
  input logic              ev_sub
);

  // R10
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R2
  fetch_addr_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_rd |-> (mem_addr == pc));

  // R9
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pc_inc |=> (pc == $past(pc) + ADDR_W'(1)));

  // R3
  ind_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ind_fix |-> ir_ind);

  // R3
  ind_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ind_fix |=> (ir_addr == $past(mbr[ADDR_W-1:0])));

  // R4
  add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_add |=> (r0 == $past(r0) + $past(mbr)));

  // R4
  sub_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sub |=> (r0 == $past(r0) - $past(mbr)));

  // R5
  wr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wdata == r0));

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_rd && !mem_wr));

endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .halted      (halted),
  .pc          (pc),
  .r0          (r0),
  .mbr         (mbr),
  .ir_addr     (ir_addr),
  .ir_ind      (ir_ind),
  .ev_fetch_rd (ev_fetch_rd),
  .ev_pc_inc   (ev_pc_inc),
  .ev_ind_fix  (ev_ind_fix),
  .ev_add      (ev_add),
  .ev_sub      (ev_sub)
);

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;

  localparam int MEMN = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_rd;
  logic        mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        halted;

  logic [15:0] mem [MEMN];
  logic [15:0] em  [MEMN];

  int n_chk = 0;
  int n_err = 0;
  int n_rd = 0, n_wr = 0, n_both = 0, rd_idx = 0;
  logic [11:0] rd_log [64];

  always #4 clk = ~clk;

  acc_core u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  // memory model: one cycle read latency
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
  end

  // bus monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) begin
        if (rd_idx < 64) rd_log[rd_idx] = mem_addr;
        rd_idx++;
        n_rd++;
      end
      if (mem_wr) n_wr++;
      if (mem_rd && mem_wr) n_both++;
    end
  end

  function automatic logic [15:0] enc(input logic [3:0] opc, input logic [11:0] a);
    return {a, opc};
  endfunction

  function automatic logic [15:0] ref_add(input logic [15:0] a, input logic [15:0] b);
    return 16'((32'(a) + 32'(b)) % 32'd65536);
  endfunction

  function automatic logic [15:0] ref_sub(input logic [15:0] a, input logic [15:0] b);
    return 16'((32'd65536 + 32'(a) - 32'(b)) % 32'd65536);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [15:0] v);
    mem[a % MEMN] <= v;
  endtask

  task automatic begin_prog();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < MEMN; i++) mem[i] <= '0;
  endtask

  // bench model of the instruction set
  task automatic iss(output int cyc, output int nst);
    logic [11:0] pc;
    logic [15:0] acc;
    logic [15:0] w;
    logic [11:0] a;
    for (int i = 0; i < MEMN; i++) em[i] = mem[i];
    pc = '0; acc = '0; cyc = 0; nst = 0;
    for (int s = 0; s < 400; s++) begin
      w = em[pc[9:0]];
      pc = 12'((13'(pc) + 13'd1) % 13'd4096);
      cyc += 5;
      a = w[15:4];
      if (w[3]) begin
        a = em[a[9:0]][11:0];
        cyc += 4;
      end
      case (w[2:0])
        3'd0: begin cyc += 1; break; end
        3'd1: begin acc = em[a[9:0]]; cyc += 4; end
        3'd2: begin em[a[9:0]] = acc; cyc += 3; nst++; end
        3'd3: begin acc = ref_add(acc, em[a[9:0]]); cyc += 4; end
        3'd4: begin acc = ref_sub(acc, em[a[9:0]]); cyc += 4; end
        3'd5: begin pc = a; cyc += 1; end
        3'd6: begin if (acc == 16'd0) pc = a; cyc += 1; end
        default: cyc += 1;
      endcase
    end
  endtask

  task automatic launch(output int cyc);
    #1;
    n_rd = 0; n_wr = 0; n_both = 0; rd_idx = 0;
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 4000) begin
      @(posedge clk);
      #2;
      cyc++;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int cyc, ecyc, est, hold_rd, hold_wr;
    void'($urandom(32'd1207));

    // ---- D1: reset state (R8), pointer load (R3), fetch order (R2)
    begin_prog();
    put(0, enc(4'd9, 12'h300));      // load via pointer
    put(1, enc(4'd2, 12'h210));      // store
    put(2, enc(4'd0, 12'h000));      // halt
    put(12'h300, 16'hF205);
    put(12'h205, 16'h1234);
    #1;
    chk("R8 strobe rd in reset", mem_rd, 0);
    chk("R8 strobe wr in reset", mem_wr, 0);
    chk("R8 halted in reset", halted, 0);
    chk("R8 addr in reset", mem_addr, 0);
    chk("R8 wdata in reset", mem_wdata, 0);
    launch(cyc);
    chk("R3 pointer load cycles", cyc, 27);
    chk("R8 first fetch at 0", rd_log[0], 12'h000);
    chk("R3 pointer read address", rd_log[1], 12'h300);
    chk("R3 operand address from pointer low bits", rd_log[2], 12'h205);
    chk("R2 next fetch address", rd_log[3], 12'h001);
    chk("R2 read strobe count", n_rd, 5);
    chk("R3 loaded value stored", mem[12'h210], 16'h1234);

    // ---- D2: arithmetic wrap (R4), halt hold (R7)
    begin_prog();
    put(0, enc(4'd1, 12'h200));
    put(1, enc(4'd3, 12'h201));
    put(2, enc(4'd2, 12'h210));
    put(3, enc(4'd1, 12'h202));
    put(4, enc(4'd4, 12'h201));
    put(5, enc(4'd2, 12'h211));
    put(6, enc(4'd0, 12'h000));
    put(12'h200, 16'hFFFF);
    put(12'h201, 16'h0002);
    put(12'h202, 16'h0000);
    launch(cyc);
    chk("R4 add wraps", mem[12'h210], 16'h0001);
    chk("R4 sub wraps", mem[12'h211], 16'hFFFE);
    chk("R4 cycles", cyc, 6 * 9 - 2 + 6);
    hold_rd = n_rd; hold_wr = n_wr;
    repeat (20) @(negedge clk);
    chk("R7 halted holds", halted, 1);
    chk("R7 no reads after halt", n_rd, hold_rd);
    chk("R7 no writes after halt", n_wr, hold_wr);

    // ---- D3: jump skips a store (R6)
    begin_prog();
    put(0, enc(4'd5, 12'h005));
    put(1, enc(4'd2, 12'h211));
    put(5, enc(4'd1, 12'h200));
    put(6, enc(4'd2, 12'h213));
    put(7, enc(4'd0, 12'h000));
    put(12'h200, 16'h4321);
    put(12'h211, 16'hAAAA);
    launch(cyc);
    chk("R6 jump target fetched", rd_log[1], 12'h005);
    chk("R6 skipped store left word", mem[12'h211], 16'hAAAA);
    chk("R6 code after jump ran", mem[12'h213], 16'h4321);
    chk("R6 jump cycles", cyc, 6 + 9 + 8 + 6);

    // ---- D4: taken and untaken jz, counter wrap (R9)
    begin_prog();
    put(0, enc(4'd6, 12'hFFF));
    put(1, enc(4'd2, 12'h212));
    put(2, enc(4'd0, 12'h000));
    put(12'hFFF, enc(4'd1, 12'h200));
    put(12'h200, 16'h0005);
    launch(cyc);
    chk("R6 jz taken to top address", rd_log[1], 12'hFFF);
    chk("R9 counter wraps to 0", rd_log[3], 12'h000);
    chk("R6 jz not taken falls through", rd_log[4], 12'h001);
    chk("R9 stored after wrap", mem[12'h212], 16'h0005);
    chk("R9 cycles", cyc, 35);

    // ---- random programs (R1, R2, R3, R4, R5, R10)
    for (int p = 0; p < 40; p++) begin
      int L;
      L = 16;
      begin_prog();
      for (int j = 0; j < 16; j++) begin
        put(12'h200 + j, 16'($urandom));
        put(12'h300 + j, {4'($urandom), 12'h200 + 12'(j)});
      end
      for (int i = 0; i < L; i++) begin
        int k, j;
        logic ind;
        k = $urandom % 6;
        j = $urandom % 16;
        ind = 1'($urandom);
        case (k)
          0: put(i, enc({ind, 3'd1}, ind ? 12'h300 + 12'(j) : 12'h200 + 12'(j)));
          1: put(i, enc({ind, 3'd2}, ind ? 12'h300 + 12'(j) : 12'h200 + 12'(j)));
          2: put(i, enc({ind, 3'd3}, ind ? 12'h300 + 12'(j) : 12'h200 + 12'(j)));
          3: put(i, enc({ind, 3'd4}, ind ? 12'h300 + 12'(j) : 12'h200 + 12'(j)));
          4: put(i, enc(4'd6, 12'(i + 2)));
          default: put(i, enc(4'd7, 12'($urandom)));
        endcase
      end
      put(L, enc(4'd2, 12'h20F));
      put(L + 1, enc(4'd0, 12'h000));
      #1;
      iss(ecyc, est);
      launch(cyc);
      chk("R2 R3 cycle count", cyc, ecyc);
      chk("R5 write strobe count", n_wr, est);
      chk("R10 strobes overlap", n_both, 0);
      for (int j = 0; j < 16; j++)
        chk("R1 R4 data word", mem[12'h200 + j], em[12'h200 + j]);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule